// File: doc/BRIEF.md
# Two-Bit-Per-Cycle Serial Adder

This block adds two unsigned operands that arrive a few bits at a time, least significant digit first. Each clock it takes one digit of each operand and returns the matching digit of the sum in the same cycle. It is the bit-serial adder widened to a digit of two bits: two one-bit full adders are chained inside the cycle, and one carry flip-flop links a digit to the next. The default word is four bits, so a word passes in two cycles.

Words follow one another with no gap. A strobe marks the cycle that carries the lowest digit of a word. On that cycle the adder ignores whatever carry is stored and uses zero as the carry into bit 0. The carry left over after the top digit of a word is therefore dropped, so each word's result is the sum modulo 2^W. The word width must be a whole multiple of the digit width.

Top module: `digit_serial_adder`

## Requirements
- R1: After reset, with the strobe low, the stored carry is zero: the first digit's sum equals a_digit + b_digit truncated to the digit width.
- R2: When word_start is 1, the carry into bit 0 is zero whatever carry is stored. The digit sum is then a_digit + b_digit truncated to the digit width.
- R3: When word_start is 0, the carry out of the top bit of the previous cycle's digit is added into bit 0 of the current digit.
- R4: Inside one cycle, the carry out of each lower bit feeds the next higher bit, so {carry out, sum_digit} equals a_digit + b_digit + carry in.
- R5: The carry out of the top digit of a word does not reach the next word. Each word's result wraps modulo 2^W.
- R6: Digits fed LSB first, with word_start high on the first digit of each word and low on the rest, reassemble (digit k at bits k*DIGIT_W and up) to (a + b) mod 2^W. This holds for back-to-back words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the stored carry |
| word_start | input | 1 | High on the cycle that carries the lowest digit of a word |
| a_digit | input | DIGIT_W | Current digit of operand a |
| b_digit | input | DIGIT_W | Current digit of operand b |
| sum_digit | output | DIGIT_W | Current digit of the sum, combinational from the inputs and the stored carry |

## Verification
The bench goes after the carry at the seams of the design. It checks a carry stored from a word's top digit while the next word starts. A design that failed to clear it would add one into that word. It checks a carry that must cross from the low digit to the high digit of one word. A design that failed to store it would give sums that are short by four. It checks two ones in the low lane, which must ripple into the upper lane in the same cycle. A design that took a registered carry there would lose the bit. All-ones operands and sums that wrap to zero show whether the result is truncated rather than spilled into the next word.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

  typedef struct packed {
    logic carry;
    logic sum;
  } fa_res_t;

  // one-bit full adder written as gate equations
  function automatic fa_res_t full_add(input logic x, input logic y, input logic cin);
    fa_res_t r;
    r.sum   = x ^ y ^ cin;
    r.carry = (x & y) | (cin & (x ^ y));
    return r;
  endfunction

endpackage

// File: rtl/dsa_carry_sel.sv
module dsa_carry_sel (
  input  logic word_start,
  input  logic carry_stored,
  output logic carry_in
);
  // switch on the feedback edge: zero at the first digit of a word
  always_comb begin
    if (word_start) carry_in = 1'b0;
    else            carry_in = carry_stored;
  end
endmodule

// File: rtl/dsa_digit_slice.sv
module dsa_digit_slice #(
  parameter int DIGIT_W = 2
) (
  input  logic [DIGIT_W-1:0] a,
  input  logic [DIGIT_W-1:0] b,
  input  logic               cin,
  output logic [DIGIT_W-1:0] sum,
  output logic [DIGIT_W:0]   lane_carry
);
  import dsa_pkg::*;

  assign lane_carry[0] = cin;

  for (genvar i = 0; i < DIGIT_W; i++) begin : g_lane
    fa_res_t res;
    always_comb res = full_add(a[i], b[i], lane_carry[i]);
    assign sum[i]          = res.sum;
    assign lane_carry[i+1] = res.carry;
  end
endmodule

// File: rtl/dsa_carry_reg.sv
module dsa_carry_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end
endmodule

// File: rtl/digit_serial_adder.sv
module digit_serial_adder #(
  parameter int WORD_W  = 4,
  parameter int DIGIT_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               word_start,
  input  logic [DIGIT_W-1:0] a_digit,
  input  logic [DIGIT_W-1:0] b_digit,
  output logic [DIGIT_W-1:0] sum_digit
);
  localparam int DIGITS_PER_WORD = WORD_W / DIGIT_W;
  localparam int EXT_W           = DIGIT_W + 1;

  // named internal events
  logic             carry_q;
  logic             carry_in_w;
  logic             carry_out_w;
  logic [DIGIT_W:0] lane_carry_w;

  dsa_carry_sel u_sel (
    .word_start   (word_start),
    .carry_stored (carry_q),
    .carry_in     (carry_in_w)
  );

  dsa_digit_slice #(.DIGIT_W(DIGIT_W)) u_slice (
    .a          (a_digit),
    .b          (b_digit),
    .cin        (carry_in_w),
    .sum        (sum_digit),
    .lane_carry (lane_carry_w)
  );

  assign carry_out_w = lane_carry_w[DIGIT_W];

  dsa_carry_reg u_creg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (carry_out_w),
    .q     (carry_q)
  );

  // ---------------- assertions ----------------
  logic [EXT_W-1:0] a_ext, b_ext;
  assign a_ext = {1'b0, a_digit};
  assign b_ext = {1'b0, b_digit};

  // R1: first digit after reset sees no stored carry
  assert_reset_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rst_n) && !word_start) |-> (sum_digit == DIGIT_W'(a_ext + b_ext)));

  // R2: strobe forces a zero carry into bit 0
  assert_start_no_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_start |-> (sum_digit == DIGIT_W'(a_ext + b_ext)));

  // R3: previous top carry enters bit 0 when no strobe
  assert_carry_chain_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !word_start) |->
      (sum_digit == DIGIT_W'(a_ext + b_ext + EXT_W'($past(carry_out_w)))));

  // R4: in-cycle ripple gives the arithmetic sum of the digit
  assert_ripple_R4: assert property (@(posedge clk) disable iff (!rst_n)
    {carry_out_w, sum_digit} == (a_ext + b_ext + EXT_W'(carry_in_w)));

  // word width must be a whole number of digits
  initial assert_word_multiple: assert (DIGITS_PER_WORD * DIGIT_W == WORD_W);
endmodule

// File: tb/digit_serial_adder_tb.sv
module digit_serial_adder_tb;
  localparam int WORD_W  = 4;
  localparam int DIGIT_W = 2;
  localparam int NDIG    = WORD_W / DIGIT_W;
  localparam int NVEC    = 12;
  // each entry: {a, b}
  localparam logic [2*WORD_W-1:0] VECS [NVEC] = '{
    8'hF1, 8'h79, 8'h55, 8'h31, 8'h00, 8'hFF,
    8'h88, 8'h66, 8'hA5, 8'hC4, 8'h23, 8'hFE
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic word_start = 1'b0;
  logic [DIGIT_W-1:0] a_digit = '0, b_digit = '0;
  logic [DIGIT_W-1:0] sum_digit;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  digit_serial_adder #(.WORD_W(WORD_W), .DIGIT_W(DIGIT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .word_start(word_start),
    .a_digit(a_digit), .b_digit(b_digit), .sum_digit(sum_digit)
  );

  task automatic check(input string req, input logic [WORD_W-1:0] got, input logic [WORD_W-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive one digit at the falling edge, sample mid-low phase
  task automatic step(input logic ws, input logic [DIGIT_W-1:0] a, input logic [DIGIT_W-1:0] b,
                      output logic [DIGIT_W-1:0] s);
    @(negedge clk);
    word_start = ws; a_digit = a; b_digit = b;
    #5;
    s = sum_digit;
  endtask

  task automatic run_word(input string req, input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b);
    logic [WORD_W-1:0] acc;
    logic [DIGIT_W-1:0] s;
    logic [WORD_W-1:0] exp;
    acc = '0;
    for (int d = 0; d < NDIG; d++) begin
      step(d == 0, a[d*DIGIT_W +: DIGIT_W], b[d*DIGIT_W +: DIGIT_W], s);
      acc[d*DIGIT_W +: DIGIT_W] = s;
    end
    exp = WORD_W'(a + b);
    check(req, acc, exp);
  endtask

  initial begin
    logic [DIGIT_W-1:0] s;
    repeat (3) @(negedge clk);
    a_digit = 2'b01; b_digit = 2'b00;
    @(negedge clk); rst_n = 1'b1;
    #5;
    // R1: stored carry is zero after reset
    check("R1", WORD_W'(sum_digit), 4'h1);

    // R6 and R5: table of back-to-back words
    for (int i = 0; i < NVEC; i++)
      run_word("R6", VECS[i][2*WORD_W-1:WORD_W], VECS[i][WORD_W-1:0]);

    // R4: low-lane carry ripples into the upper bit in the same cycle
    step(1'b1, 2'b01, 2'b01, s);
    check("R4", WORD_W'(s), 4'h2);

    // R2: stored carry set, then strobe must ignore it
    step(1'b1, 2'b11, 2'b01, s);
    check("R4", WORD_W'(s), 4'h0);
    step(1'b1, 2'b00, 2'b00, s);
    check("R2", WORD_W'(s), 4'h0);
    step(1'b0, 2'b00, 2'b00, s);
    check("R2", WORD_W'(s), 4'h0);

    // R3: top carry enters next digit without strobe
    step(1'b1, 2'b10, 2'b10, s);
    check("R3", WORD_W'(s), 4'h0);
    step(1'b0, 2'b00, 2'b00, s);
    check("R3", WORD_W'(s), 4'h1);
    step(1'b1, 2'b11, 2'b11, s);
    step(1'b0, 2'b01, 2'b10, s);
    check("R3", WORD_W'(s), 4'h0);

    // R5: all-ones word leaves a carry that the next word drops
    run_word("R5", 4'hF, 4'hF);
    run_word("R5", 4'h0, 4'h0);

    // R6: pseudo-random back-to-back words
    for (int i = 0; i < 40; i++)
      run_word("R6", WORD_W'($urandom_range(0, 15)), WORD_W'($urandom_range(0, 15)));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule